// File: doc/BRIEF.md
# Halfword and Signed-Byte Address Generator

This block forms the memory address for the load/store class that moves halfwords, signed bytes and doublewords. Each request carries a base register value and one of two offset sources: an 8-bit immediate delivered as two 4-bit halves, or a full register value. Control bits choose the offset source, whether the offset is added or subtracted, whether it is applied before the access (offset or pre-indexed) or only to the updated base (post-indexed), and whether the base is written back.

A request is accepted when `in_valid` is high. One clock later the block presents the access address, the updated base value, a writeback enable and a flag for encodings that are not loads or stores. `out_valid` marks that cycle. The block does not touch memory, check alignment or write the register file. The pipeline stage that owns those actions consumes these outputs.

Top module: `hs_addr_gen`

## Requirements
- R1: With `imm_sel`=1, the offset is `imm_hi` placed in bits 7:4 and `imm_lo` in bits 3:0, zero-extended to 32 bits, so it spans 0 to 255.
- R2: With `imm_sel`=0, the offset is the 32-bit value on `rm_val`.
- R3: The offset address is `base_val` + offset when `up_dir`=1 and `base_val` − offset when `up_dir`=0, taken modulo 2^32. `wb_value` carries this offset address.
- R4: `mem_addr` is the offset address when `pre_idx`=1 and the unmodified `base_val` when `pre_idx`=0.
- R5: When `pre_idx`=1, `mem_addr` and `wb_value` of the same result are equal.
- R6: `wb_en` is 1 exactly when `pre_idx` equals `wb_bit` and `sh_code` is not 2'b00. The case `pre_idx`=1, `wb_bit`=0 never writes back.
- R7: `illegal` is 1 exactly when `sh_code` is 2'b00. Such a request never asserts `wb_en`.
- R8: Every result appears one clock after the request. `out_valid` is `in_valid` delayed by one clock. While `in_valid` is low, all result outputs keep their last value.
- R9: Synchronous active-high `rst` clears `out_valid`, `mem_addr`, `wb_value`, `wb_en` and `illegal` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| base_val | input | 32 | Base register value |
| rm_val | input | 32 | Register offset value |
| imm_hi | input | 4 | Upper half of immediate offset |
| imm_lo | input | 4 | Lower half of immediate offset |
| imm_sel | input | 1 | 1 selects immediate offset, 0 selects register offset |
| pre_idx | input | 1 | 1 applies offset to the access address |
| up_dir | input | 1 | 1 adds the offset, 0 subtracts it |
| wb_bit | input | 1 | Writeback control bit |
| sh_code | input | 2 | Transfer kind; 2'b00 is not a load/store |
| out_valid | output | 1 | Result valid, one cycle after request |
| mem_addr | output | 32 | Access address |
| wb_value | output | 32 | Updated base value |
| wb_en | output | 1 | Base writeback enable |
| illegal | output | 1 | Non-load/store encoding flag |

## Verification
Every combination of `pre_idx`, `up_dir` and `wb_bit` is tried with both offset sources. This separates add from subtract, offset from post-indexed addressing, and the four writeback cases. Each combination runs over three data sets: an ordinary midrange base, a zero base that wraps below zero on subtraction, and a base near the top that wraps on addition with a full 0xFF immediate. These sets expose carry, borrow and nibble-order faults. `sh_code`=2'b00 is applied with writeback-enabling control bits to confirm that `wb_en` is suppressed. Changing inputs while `in_valid` is low confirms that the held outputs do not move.

// File: rtl/hs_agen_pkg.sv
package hs_agen_pkg;

    typedef enum logic [1:0] {
        XFER_NONE  = 2'b00,
        XFER_UHALF = 2'b01,
        XFER_SBYTE = 2'b10,
        XFER_SHALF = 2'b11
    } xfer_kind_e;

    typedef struct packed {
        logic       pre_idx;
        logic       up_dir;
        logic       wb_bit;
        xfer_kind_e kind;
    } agen_ctl_t;

    // writeback happens for offset+W and for post-indexed forms
    function automatic logic wb_wanted(agen_ctl_t c);
        return (c.pre_idx == c.wb_bit) && (c.kind != XFER_NONE);
    endfunction

    function automatic logic is_illegal(agen_ctl_t c);
        return c.kind == XFER_NONE;
    endfunction

endpackage

// File: rtl/hs_offset_sel.sv
module hs_offset_sel #(
    parameter int ADDR_W = 32,
    parameter int NIB_W  = 4
) (
    input  logic              imm_sel,
    input  logic [NIB_W-1:0]  imm_hi,
    input  logic [NIB_W-1:0]  imm_lo,
    input  logic [ADDR_W-1:0] rm_val,
    output logic [ADDR_W-1:0] offset
);
    localparam int IMM_W = 2 * NIB_W;

    logic [ADDR_W-1:0] imm_ext;

    generate
        if (ADDR_W > IMM_W) begin : g_pad
            assign imm_ext = {{(ADDR_W-IMM_W){1'b0}}, imm_hi, imm_lo};
        end else begin : g_nopad
            assign imm_ext = {imm_hi, imm_lo};
        end
    endgenerate

    assign offset = imm_sel ? imm_ext : rm_val;

endmodule

// File: rtl/hs_addr_calc.sv
module hs_addr_calc
    import hs_agen_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] offset,
    input  agen_ctl_t         ctl,
    output logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] upd_base,
    output logic              upd_en,
    output logic              bad_enc
);
    logic [ADDR_W-1:0] offs_addr;

    always_comb begin
        offs_addr = ctl.up_dir ? (base + offset) : (base - offset);
        addr      = ctl.pre_idx ? offs_addr : base;
        upd_base  = offs_addr;
        upd_en    = wb_wanted(ctl);
        bad_enc   = is_illegal(ctl);
    end

endmodule

// File: rtl/hs_out_reg.sv
module hs_out_reg #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              d_valid,
    input  logic [ADDR_W-1:0] d_addr,
    input  logic [ADDR_W-1:0] d_wb,
    input  logic              d_wben,
    input  logic              d_ill,
    output logic              q_valid,
    output logic [ADDR_W-1:0] q_addr,
    output logic [ADDR_W-1:0] q_wb,
    output logic              q_wben,
    output logic              q_ill
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid <= 1'b0;
            q_addr  <= '0;
            q_wb    <= '0;
            q_wben  <= 1'b0;
            q_ill   <= 1'b0;
        end else begin
            q_valid <= d_valid;
            if (d_valid) begin
                q_addr <= d_addr;
                q_wb   <= d_wb;
                q_wben <= d_wben;
                q_ill  <= d_ill;
            end
        end
    end

    a_r8_hold_addr: assert property (@(posedge clk) disable iff (rst)
        !d_valid |=> $stable(q_addr) && $stable(q_wb));

endmodule

// File: rtl/hs_addr_gen.sv
module hs_addr_gen
    import hs_agen_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NIB_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [ADDR_W-1:0] rm_val,
    input  logic [NIB_W-1:0]  imm_hi,
    input  logic [NIB_W-1:0]  imm_lo,
    input  logic              imm_sel,
    input  logic              pre_idx,
    input  logic              up_dir,
    input  logic              wb_bit,
    input  logic [1:0]        sh_code,
    output logic              out_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] wb_value,
    output logic              wb_en,
    output logic              illegal
);
    agen_ctl_t         ctl;
    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] c_addr;
    logic [ADDR_W-1:0] c_wb;
    logic              c_wben;
    logic              c_ill;

    assign ctl = '{pre_idx: pre_idx, up_dir: up_dir, wb_bit: wb_bit,
                   kind: xfer_kind_e'(sh_code)};

    hs_offset_sel #(.ADDR_W(ADDR_W), .NIB_W(NIB_W)) i_offs (
        .imm_sel (imm_sel),
        .imm_hi  (imm_hi),
        .imm_lo  (imm_lo),
        .rm_val  (rm_val),
        .offset  (offset)
    );

    hs_addr_calc #(.ADDR_W(ADDR_W)) i_calc (
        .base     (base_val),
        .offset   (offset),
        .ctl      (ctl),
        .addr     (c_addr),
        .upd_base (c_wb),
        .upd_en   (c_wben),
        .bad_enc  (c_ill)
    );

    hs_out_reg #(.ADDR_W(ADDR_W)) i_oreg (
        .clk     (clk),
        .rst     (rst),
        .d_valid (in_valid),
        .d_addr  (c_addr),
        .d_wb    (c_wb),
        .d_wben  (c_wben),
        .d_ill   (c_ill),
        .q_valid (out_valid),
        .q_addr  (mem_addr),
        .q_wb    (wb_value),
        .q_wben  (wb_en),
        .q_ill   (illegal)
    );

    a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r8_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r4_post_uses_base: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !pre_idx) |=> mem_addr == $past(base_val));

    a_r5_pre_matches_wb: assert property (@(posedge clk) disable iff (rst)
        (in_valid && pre_idx) |=> mem_addr == wb_value);

    a_r7_no_wb_when_illegal: assert property (@(posedge clk) disable iff (rst)
        (out_valid && illegal) |-> !wb_en);

    a_r6_no_wb_offset_only: assert property (@(posedge clk) disable iff (rst)
        (in_valid && pre_idx && !wb_bit) |=> !wb_en);

endmodule

// File: tb/test_hs_addr_gen.sv
module test_hs_addr_gen;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] base_val, rm_val;
    logic [3:0]  imm_hi, imm_lo;
    logic        imm_sel, pre_idx, up_dir, wb_bit;
    logic [1:0]  sh_code;
    logic        out_valid, wb_en, illegal;
    logic [31:0] mem_addr, wb_value;

    int total = 0;
    int fails = 0;

    always #5 clk = ~clk;

    hs_addr_gen i_hs_addr_gen (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .base_val(base_val), .rm_val(rm_val),
        .imm_hi(imm_hi), .imm_lo(imm_lo), .imm_sel(imm_sel),
        .pre_idx(pre_idx), .up_dir(up_dir), .wb_bit(wb_bit),
        .sh_code(sh_code), .out_valid(out_valid), .mem_addr(mem_addr),
        .wb_value(wb_value), .wb_en(wb_en), .illegal(illegal)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // behavioural reference and one-request driver
    task automatic run_req(input logic [31:0] b, input logic [31:0] r,
                           input logic [3:0] hi, input logic [3:0] lo,
                           input logic is, input logic p, input logic u,
                           input logic w, input logic [1:0] sh);
        longint off, oa, ad;
        logic   ewb, eill;
        off  = is ? longint'(hi) * 16 + longint'(lo) : longint'(r);
        oa   = u ? (longint'(b) + off) : (longint'(b) - off);
        oa   = oa & 64'hFFFF_FFFF;
        ad   = p ? oa : longint'(b);
        eill = (sh == 2'b00);
        ewb  = (p == w) && !eill;
        @(negedge clk);
        base_val = b; rm_val = r; imm_hi = hi; imm_lo = lo;
        imm_sel = is; pre_idx = p; up_dir = u; wb_bit = w; sh_code = sh;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8 out_valid", {31'b0, out_valid}, 32'd1);
        chk("R4 mem_addr", mem_addr, ad[31:0]);
        chk("R3 wb_value", wb_value, oa[31:0]);
        if (is) chk("R1 imm offset via wb_value", wb_value, oa[31:0]);
        else    chk("R2 reg offset via wb_value", wb_value, oa[31:0]);
        if (p)  chk("R5 pre addr equals wb", mem_addr, wb_value);
        chk("R6 wb_en", {31'b0, wb_en}, {31'b0, ewb});
        chk("R7 illegal", {31'b0, illegal}, {31'b0, eill});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0;
        base_val = '0; rm_val = '0; imm_hi = '0; imm_lo = '0;
        imm_sel = 1'b0; pre_idx = 1'b0; up_dir = 1'b0; wb_bit = 1'b0;
        sh_code = 2'b01;
        repeat (3) @(negedge clk);
        chk("R9 out_valid", {31'b0, out_valid}, 32'd0);
        chk("R9 mem_addr", mem_addr, 32'd0);
        chk("R9 wb_value", wb_value, 32'd0);
        chk("R9 wb_en", {31'b0, wb_en}, 32'd0);
        chk("R9 illegal", {31'b0, illegal}, 32'd0);
        rst = 1'b0;

        for (int p = 0; p < 2; p++)
            for (int u = 0; u < 2; u++)
                for (int w = 0; w < 2; w++)
                    for (int is = 0; is < 2; is++) begin
                        run_req(32'h0000_1000, 32'h0000_0124, 4'h3, 4'hC,
                                is[0], p[0], u[0], w[0], 2'b01);
                        run_req(32'h0000_0000, 32'h0000_0001, 4'h0, 4'h1,
                                is[0], p[0], u[0], w[0], 2'b10);
                        run_req(32'hFFFF_FFF0, 32'h0000_0020, 4'hF, 4'hF,
                                is[0], p[0], u[0], w[0], 2'b11);
                    end

        // R7: non-load/store encoding with writeback-enabling bits
        run_req(32'h8000_0000, 32'h10, 4'h1, 4'h2, 1'b1, 1'b1, 1'b1, 1'b1, 2'b00);
        run_req(32'h8000_0000, 32'h10, 4'h1, 4'h2, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00);

        // R8: outputs hold while idle even though inputs change
        run_req(32'h0000_2000, 32'h40, 4'h0, 4'h0, 1'b0, 1'b1, 1'b1, 1'b1, 2'b01);
        @(negedge clk);
        base_val = 32'hDEAD_0000; rm_val = 32'h1234; pre_idx = 1'b0; wb_bit = 1'b1;
        sh_code = 2'b00;
        @(negedge clk);
        @(negedge clk);
        chk("R8 idle out_valid", {31'b0, out_valid}, 32'd0);
        chk("R8 hold mem_addr", mem_addr, 32'h0000_2040);
        chk("R8 hold wb_value", wb_value, 32'h0000_2040);
        chk("R8 hold wb_en", {31'b0, wb_en}, 32'd1);
        chk("R8 hold illegal", {31'b0, illegal}, 32'd0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule